// File: doc/BRIEF.md
# Vertical Wipe Line Controller

This block produces a vertical wipe for an on-screen-display overlay. Software programs one 8-bit control word over a simple write strobe. The word selects an operating mode, a wipe direction, a step size and a final line. The block counts horizontal sync pulses inside each field to know which line is being scanned. On every vertical sync it moves an internal boundary line further down the screen by the chosen step.

For every line the block drives a display-enable flag. In UP direction the flag marks lines above the boundary, so the revealed region grows as the boundary moves. In DOWN direction it marks lines at or below the boundary, so the revealed region shrinks. When the boundary reaches the programmed final line it stops there and a sticky completion flag is raised. Any new write to the control word restarts the wipe from line zero.

Top module: `wipe_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset the control word reads 0, the mode is off, `disp_en` is 1 and `wipe_done` is 0.
- R2: A write stores `wr_data[6:0]` as the control word, and `rd_data` returns it on the next cycle. Bit 7 is not stored and always reads 0. The fields are: mode in bits 1:0, direction in bit 2, step code in bits 4:3, and stop code in bits 6:5.
- R3: The line count returns to 0 in the cycle after a `vsync_pulse` (vsync wins over hsync). Otherwise it rises by one after each `hsync_pulse` and saturates at its maximum.
- R4: In modes 1 (code 01) and 2 (code 10), each vsync advances the boundary by the step code: 00 gives 1 line, 01 gives 2 lines, 10 gives 4 lines. Code 11 must not be programmed.
- R5: In mode 3 (code 11) each vsync advances the boundary by 4 lines, whatever the step code holds.
- R6: The boundary never passes the stop line selected by bits 6:5: 00 gives 312, 01 gives 156, 10 gives 256, 11 gives 128.
- R7: With bit 2 = 1 (UP) and a mode other than off, `disp_en` is 1 exactly while the line count is below the boundary.
- R8: With bit 2 = 0 (DOWN) and a mode other than off, `disp_en` is 1 exactly while the line count is at or above the boundary.
- R9: When a vsync step would reach or pass the stop line, the boundary is set to the stop line and `wipe_done` rises. Both then hold through later vsyncs until the next write.
- R10: Every write clears the boundary to 0 and clears `wipe_done`. A write wins over a vsync in the same cycle.
- R11: With mode 00 the wipe is off: `disp_en` is 1 on every line and vsync does not move the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write data |
| rd_data | output | 8 | Control word readback, bit 7 always 0 |
| hsync_pulse | input | 1 | One-cycle pulse per scan line |
| vsync_pulse | input | 1 | One-cycle pulse per field |
| disp_en | output | 1 | Current line lies in the revealed region |
| wipe_done | output | 1 | Sticky flag: boundary has reached the stop line |

## Verification
The bench drives the wipe until the boundary lands exactly on each of the four stop lines. A design that overshoots, or wraps past the stop line, would give a wrong enable edge in long fields once the step is applied at the limit.

Mode 3 is run with a step code of 01. This exposes a design that obeys the step code in that mode, because its boundary would move 2 lines per field instead of 4.

Writes are issued in the same cycle as a vsync, and again after completion. A wrong priority would leave the boundary advanced, or `wipe_done` stuck high.

Mode off is exercised across several fields. A design that gates the enable, or moves the boundary while off, would blank lines.

// File: rtl/wipe_pkg.sv
// Package: shared control-word layout and field codes for the wipe controller.
// Assumes the control word is seven implemented bits; bit 7 does not exist.
package wipe_pkg;

    typedef enum logic [1:0] {
        WIPE_OFF = 2'b00,
        WIPE_M1  = 2'b01,
        WIPE_M2  = 2'b10,
        WIPE_M3  = 2'b11
    } wipe_mode_e;

    // Packed so the bit positions match the software-visible word.
    typedef struct packed {
        logic [1:0] stop_sel;   // bits 6:5
        logic [1:0] step_sel;   // bits 4:3
        logic       dir_up;     // bit 2
        wipe_mode_e mode;       // bits 1:0
    } wipe_ctrl_t;

    localparam int CTRL_W = $bits(wipe_ctrl_t);

endpackage

// File: rtl/wipe_ctrl_reg.sv
// Module: control register. Stores seven implemented bits on a write strobe.
// Readback pads bit 7 with zero. Assumes wr_en is a single-cycle strobe.
module wipe_ctrl_reg
    import wipe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output wipe_ctrl_t  ctrl,
    output logic [7:0]  rd_data
);

    // Capture the implemented bits of a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en)
            ctrl <= wipe_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // Form the readback word with the missing top bit as zero.
    always_comb begin
        rd_data = {1'b0, ctrl};
    end

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == {1'b0, $past(wr_data[6:0])}));

endmodule

// File: rtl/wipe_line_counter.sv
// Module: per-field scan line counter. Clears on vsync and counts hsync
// pulses. Saturates rather than wrapping if a field runs long.
// Assumes both sync inputs are one-cycle pulses in the clk domain.
module wipe_line_counter #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_pulse,
    input  logic              vsync_pulse,
    output logic [LINE_W-1:0] line_cnt
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    // Restart at each field, step once per line, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_cnt <= '0;
        else if (vsync_pulse)
            line_cnt <= '0;
        else if (hsync_pulse && line_cnt != LINE_MAX)
            line_cnt <= line_cnt + LINE_W'(1);
    end

    // R3
    field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |=> (line_cnt == '0));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_pulse && !vsync_pulse && line_cnt != LINE_MAX)
        |=> (line_cnt == $past(line_cnt) + LINE_W'(1)));

endmodule

// File: rtl/wipe_boundary.sv
// Module: wipe boundary tracker. On each vsync it advances the boundary by
// the decoded step and clamps at the decoded stop line. At the clamp it sets
// a sticky done flag. Any control write restarts the boundary at zero.
// Assumes the stop lines fit in LINE_W bits and the step code 11 is unused.
module wipe_boundary
    import wipe_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int STOP_0 = 312,
    parameter int STOP_1 = 156,
    parameter int STOP_2 = 256,
    parameter int STOP_3 = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wipe_ctrl_t        ctrl,
    input  logic              wr_en,
    input  logic              vsync_pulse,
    output logic [LINE_W-1:0] boundary,
    output logic [LINE_W-1:0] stop_line,
    output logic              done
);

    logic [LINE_W-1:0] step_lines;
    logic [LINE_W:0]   next_sum;

    // Decode the step: mode 3 fixes four lines, other modes follow the code.
    always_comb begin
        if (ctrl.mode == WIPE_M3)
            step_lines = LINE_W'(4);
        else begin
            case (ctrl.step_sel)
                2'b00:   step_lines = LINE_W'(1);
                2'b01:   step_lines = LINE_W'(2);
                default: step_lines = LINE_W'(4);
            endcase
        end
    end

    // Decode the stop line from its two-bit code.
    always_comb begin
        case (ctrl.stop_sel)
            2'b00:   stop_line = LINE_W'(STOP_0);
            2'b01:   stop_line = LINE_W'(STOP_1);
            2'b10:   stop_line = LINE_W'(STOP_2);
            default: stop_line = LINE_W'(STOP_3);
        endcase
    end

    // One extra bit so the comparison cannot wrap.
    always_comb begin
        next_sum = {1'b0, boundary} + {1'b0, step_lines};
    end

    // Advance once per field, clamp at the stop line, restart on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boundary <= '0;
            done     <= 1'b0;
        end else if (wr_en) begin
            boundary <= '0;
            done     <= 1'b0;
        end else if (vsync_pulse && ctrl.mode != WIPE_OFF && !done) begin
            if (next_sum >= {1'b0, stop_line}) begin
                boundary <= stop_line;
                done     <= 1'b1;
            end else begin
                boundary <= next_sum[LINE_W-1:0];
            end
        end
    end

    // R6
    within_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary <= stop_line);

    // R9
    done_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (boundary == stop_line));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_en) |=> (done && $stable(boundary)));

    // R10
    write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (boundary == '0 && !done));

    // R11
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_pulse && !wr_en && ctrl.mode == WIPE_OFF) |=> $stable(boundary));

    // R5
    m3_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_pulse && !wr_en && !done && ctrl.mode == WIPE_M3
         && ({1'b0, boundary} + (LINE_W+1)'(4)) < {1'b0, stop_line})
        |=> (boundary == $past(boundary) + LINE_W'(4)));

endmodule

// File: rtl/wipe_line_ctrl.sv
// Module: top of the vertical wipe controller. Joins the control register,
// the line counter and the boundary tracker. Compares the current line with
// the boundary to form the display enable for that line.
// Assumes sync pulses are already synchronised to clk.
module wipe_line_ctrl
    import wipe_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       hsync_pulse,
    input  logic       vsync_pulse,
    output logic       disp_en,
    output logic       wipe_done
);

    wipe_ctrl_t        ctrl;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] boundary;
    logic [LINE_W-1:0] stop_line;

    wipe_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    wipe_line_counter #(.LINE_W(LINE_W)) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_pulse (hsync_pulse),
        .vsync_pulse (vsync_pulse),
        .line_cnt    (line_cnt)
    );

    wipe_boundary #(.LINE_W(LINE_W)) u_bound (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .wr_en       (wr_en),
        .vsync_pulse (vsync_pulse),
        .boundary    (boundary),
        .stop_line   (stop_line),
        .done        (wipe_done)
    );

    // Choose the reveal side from the direction; show every line when off.
    always_comb begin
        if (ctrl.mode == WIPE_OFF)
            disp_en = 1'b1;
        else if (ctrl.dir_up)
            disp_en = (line_cnt < boundary);
        else
            disp_en = (line_cnt >= boundary);
    end

    // R11
    off_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] == 2'b00) |-> disp_en);

    // R7
    up_top_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] != 2'b00 && rd_data[2] && line_cnt == '0 && wipe_done)
        |-> disp_en);

    // R8
    down_top_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] != 2'b00 && !rd_data[2] && line_cnt == '0 && wipe_done)
        |-> !disp_en);

endmodule

// File: tb/wipe_line_ctrl_test.sv
// Bench: behavioural reference model updated on every rising edge.
// All outputs are compared against the model at each falling edge.
module wipe_line_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       hsync_pulse = 1'b0;
    logic       vsync_pulse = 1'b0;
    logic [7:0] rd_data;
    logic       disp_en;
    logic       wipe_done;

    int vectors = 0;
    int misses = 0;
    string cur_req = "R1";

    // Reference model state
    int m_ctrl = 0;
    int m_line = 0;
    int m_bnd = 0;
    int m_done = 0;

    always #10 clk = ~clk;

    wipe_line_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .hsync_pulse (hsync_pulse),
        .vsync_pulse (vsync_pulse),
        .disp_en     (disp_en),
        .wipe_done   (wipe_done)
    );

    // Model step size from the requirements (R4, R5)
    function automatic int model_step(int c);
        int md = c & 3;
        int sc = (c >> 3) & 3;
        if (md == 3) return 4;
        if (sc == 0) return 1;
        if (sc == 1) return 2;
        return 4;
    endfunction

    // Model stop line from the requirements (R6)
    function automatic int model_stop(int c);
        case ((c >> 5) & 3)
            0: return 312;
            1: return 156;
            2: return 256;
            default: return 128;
        endcase
    endfunction

    // Reference model update at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_line = 0; m_bnd = 0; m_done = 0;
        end else begin
            if (vsync_pulse) m_line = 0;
            else if (hsync_pulse && m_line < 1023) m_line = m_line + 1;
            if (wr_en) begin
                m_ctrl = wr_data & 8'h7F;
                m_bnd = 0;
                m_done = 0;
            end else if (vsync_pulse && (m_ctrl & 3) != 0 && m_done == 0) begin
                if (m_bnd + model_step(m_ctrl) >= model_stop(m_ctrl)) begin
                    m_bnd = model_stop(m_ctrl);
                    m_done = 1;
                end else begin
                    m_bnd = m_bnd + model_step(m_ctrl);
                end
            end
        end
    end

    function automatic logic model_en();
        if ((m_ctrl & 3) == 0) return 1'b1;
        if ((m_ctrl & 4) != 0) return m_line < m_bnd;
        return m_line >= m_bnd;
    endfunction

    task automatic compare();
        vectors++;
        if (disp_en !== model_en()) begin
            misses++;
            $display("FAIL %s disp_en actual %0b expected %0b (line %0d)",
                     cur_req, disp_en, model_en(), m_line);
        end
        if (rd_data !== 8'(m_ctrl)) begin
            misses++;
            $display("FAIL R2 rd_data actual %02h expected %02h", rd_data, 8'(m_ctrl));
        end
        if (wipe_done !== 1'(m_done)) begin
            misses++;
            $display("FAIL R9 wipe_done actual %0b expected %0b", wipe_done, m_done);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic field(input int nlines);
        vsync_pulse = 1'b1;
        tick();
        vsync_pulse = 1'b0;
        hsync_pulse = 1'b1;
        for (int i = 0; i < nlines; i++) tick();
        hsync_pulse = 1'b0;
        tick();
    endtask

    // Run fields until completion plus a few extra to check stickiness
    task automatic run_wipe(input logic [7:0] v);
        int n = 0;
        write_ctrl(v);
        while (m_done == 0 && n < 400) begin
            field((n % 4 == 3) ? 330 : 30);
            n++;
        end
        for (int k = 0; k < 3; k++) field(330);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R2: bit 7 dropped, readback of stored word
        cur_req = "R2";
        write_ctrl(8'hFF);
        tick();
        write_ctrl(8'h80);
        tick();

        // R11: wipe off across fields, R3 line counting
        cur_req = "R11";
        for (int f = 0; f < 3; f++) field(330);

        // R7 with R6 stop 128: mode 1, UP, 1-line step
        cur_req = "R7";
        run_wipe(8'h65);

        // R8 with R4 2-line step, stop 156: mode 2, DOWN
        cur_req = "R8";
        run_wipe(8'h2A);

        // R4 step code 10 as 4 lines, stop 256: mode 1, UP
        cur_req = "R4";
        run_wipe(8'h55);

        // R5 mode 3 ignores step code 01, stop 312, DOWN
        cur_req = "R5";
        run_wipe(8'h0B);

        // R10: write in the same cycle as vsync; write wins
        cur_req = "R10";
        field(40);
        wr_en = 1'b1; wr_data = 8'h07; vsync_pulse = 1'b1;
        tick();
        wr_en = 1'b0; vsync_pulse = 1'b0;
        hsync_pulse = 1'b1;
        for (int i = 0; i < 10; i++) tick();
        hsync_pulse = 1'b0;
        for (int f = 0; f < 5; f++) field(40);

        // R9: rewrite after completion clears the flag
        cur_req = "R9";
        run_wipe(8'h67);
        write_ctrl(8'h67);
        field(20);

        // R3: vsync beats hsync in the same cycle
        cur_req = "R3";
        hsync_pulse = 1'b1; vsync_pulse = 1'b1;
        tick();
        vsync_pulse = 1'b0;
        for (int i = 0; i < 12; i++) tick();
        hsync_pulse = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule